// File: doc/BRIEF.md
# Hardware Cursor Overlay Renderer

This block places a 64 by 64 pixel, 16-colour cursor on top of a video raster. For each raster pixel it receives the beam position and a valid flag. It compares the position with the cursor window and reads the matching cursor row from a local bitmap memory. It then produces, two cycles later, either a 24-bit palette colour or a pass-through flag. The pass-through flag tells the downstream mixer to show the framebuffer pixel instead.

Software programs the block through a byte-wide write port. The port carries the cursor position, the bitmap base address, the mode control byte and sixteen palette colours. Position writes land in a pending copy, which becomes active on the rising edge of vertical blanking, so the cursor never moves in the middle of a frame. The position origin is offset by 64, which lets the cursor hang partly past the top or left edge of the screen. Writing an X position of zero parks the cursor fully off screen, which is the way to hide it without turning the mode off.

Top module: `cursor_overlay`

## Requirements
- R1: The position bytes are written at these addresses: 0x00 for X bits 7:0, 0x01 for X bits 15:8, 0x02 for Y bits 7:0 and 0x03 for Y bits 15:8. A write changes only a pending copy. The pending X and Y are copied to the active position at a clock edge where vblank is high and was low at the previous edge. Pixels use only the active position.
- R2: A raster pixel (sx, sy) is covered when X-64 <= sx < X and Y-64 <= sy < Y, using the active X and Y. Its cursor column is c = sx-X+64 and its cursor row is r = sy-Y+64.
- R3: With an active X of 0, no pixel is covered, and every valid output has pass-through set.
- R4: The control byte sits at address 0x06. Only the value 4 enables the cursor. With any other value, including 0, every valid output has pass-through set.
- R5: Address 0x04 holds base address bits 17:10. Bits 5:0 of address 0x05 hold base address bits 23:18, and its bits 7:6 are ignored. For a covered, valid pixel with the cursor enabled, the block asserts mem_rd_en and drives mem_rd_addr = base + 48*r. The memory returns the 48-byte row on the next cycle, with byte k on bits 8k+7:8k.
- R6: Column c is transparent, and its output has pass-through set, when bit 7-(c mod 8) of row byte 47-c/8 is 1.
- R7: For a column that is not transparent, the palette index is bits 7:4 of row byte c/2 when c is odd, and bits 3:0 of that byte when c is even.
- R8: Palette entry i, for i from 0 to 15, is written at address 0x40+4*i+k. A write with k=0 sets colour bits 7:0, k=1 sets bits 15:8, and k=2 sets bits 23:16. A write with k=3 changes nothing.
- R9: out_valid equals px_valid from two cycles earlier. out_pass and out_rgb belong to that same pixel. out_rgb is 0 whenever out_pass is 1.
- R10: After reset, out_valid is 0, out_pass is 1 and out_rgb is 0. The positions, base address, control byte and palette all start at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register byte write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 8 | Register byte data |
| vblank | input | 1 | Vertical blanking level from the timing generator |
| px_x | input | 16 | Raster column of the current pixel |
| px_y | input | 16 | Raster line of the current pixel |
| px_valid | input | 1 | Current pixel is active video |
| mem_rd_en | output | 1 | Cursor row read request |
| mem_rd_addr | output | 24 | Byte address of the requested row |
| mem_rd_data | input | 384 | Row returned one cycle after the request |
| out_valid | output | 1 | Delayed pixel valid |
| out_pass | output | 1 | Show the framebuffer pixel |
| out_rgb | output | 24 | Cursor colour when out_pass is 0 |

## Verification
Some rules are checked on every cycle by properties. The active position may change only at a blanking rising edge. A parked X must never produce coverage. A disabled mode must force pass-through two cycles later. out_valid must follow px_valid by exactly two cycles, and a pass-through output must carry black. Other behaviour can only be shown by the bench scenarios, which compare each output against a model that decodes the same row bytes. These include the window edges when the cursor hangs off the top-left corner, the mask-bit and nibble positions within a row, the row address built from a base with ignored high bits, palette byte lanes and the unused lane, and a pending position that is not yet in effect.

// File: rtl/cursor_pkg.sv
package cursor_pkg;
  localparam int CUR_DIM   = 64;
  localparam int CUR_IDX_W = $clog2(CUR_DIM);
  localparam int ROW_BYTES = 48;
  localparam int ROW_W     = ROW_BYTES * 8;
  localparam int MADDR_W   = 24;
  localparam int BASE_LSB  = 10;
  localparam int BASE_W    = MADDR_W - BASE_LSB;
  localparam int PAL_N     = 16;
  localparam int PAL_IDX_W = $clog2(PAL_N);
  localparam int RGB_W     = 24;

  localparam logic [7:0] RA_XLO   = 8'h00;
  localparam logic [7:0] RA_XHI   = 8'h01;
  localparam logic [7:0] RA_YLO   = 8'h02;
  localparam logic [7:0] RA_YHI   = 8'h03;
  localparam logic [7:0] RA_BLO   = 8'h04;
  localparam logic [7:0] RA_BHI   = 8'h05;
  localparam logic [7:0] RA_CTRL  = 8'h06;
  localparam logic [1:0] RA_PAL_PAGE = 2'b01;
  localparam logic [7:0] CTRL_PAL16  = 8'h04;
endpackage

// File: rtl/cursor_regs.sv
module cursor_regs
  import cursor_pkg::*;
#(
  parameter int POS_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [7:0]           addr,
  input  logic [7:0]           wdata,
  input  logic                 vblank,
  output logic [POS_W-1:0]     act_x,
  output logic [POS_W-1:0]     act_y,
  output logic [BASE_W-1:0]    base,
  output logic                 mode_on,
  output logic                 pal_we,
  output logic [PAL_IDX_W-1:0] pal_idx,
  output logic [1:0]           pal_lane
);
  logic [POS_W-1:0]  pend_x_q, pend_y_q, act_x_q, act_y_q;
  logic [POS_W-1:0]  pend_x_n, pend_y_n, act_x_n, act_y_n;
  logic [BASE_W-1:0] base_q, base_n;
  logic [7:0]        ctrl_q, ctrl_n;
  logic              vb_q;
  logic              vb_rise;

  assign vb_rise = vblank && !vb_q;

  always_comb begin
    pend_x_n = pend_x_q;
    pend_y_n = pend_y_q;
    base_n   = base_q;
    ctrl_n   = ctrl_q;
    if (we) begin
      case (addr)
        RA_XLO:  pend_x_n[7:0]          = wdata;
        RA_XHI:  pend_x_n[POS_W-1:8]    = wdata[POS_W-9:0];
        RA_YLO:  pend_y_n[7:0]          = wdata;
        RA_YHI:  pend_y_n[POS_W-1:8]    = wdata[POS_W-9:0];
        RA_BLO:  base_n[7:0]            = wdata;
        RA_BHI:  base_n[BASE_W-1:8]     = wdata[BASE_W-9:0];
        RA_CTRL: ctrl_n                 = wdata;
        default: ;
      endcase
    end
    act_x_n = vb_rise ? pend_x_q : act_x_q;
    act_y_n = vb_rise ? pend_y_q : act_y_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_x_q <= '0;
      pend_y_q <= '0;
      act_x_q  <= '0;
      act_y_q  <= '0;
      base_q   <= '0;
      ctrl_q   <= '0;
      vb_q     <= 1'b0;
    end else begin
      pend_x_q <= pend_x_n;
      pend_y_q <= pend_y_n;
      act_x_q  <= act_x_n;
      act_y_q  <= act_y_n;
      base_q   <= base_n;
      ctrl_q   <= ctrl_n;
      vb_q     <= vblank;
    end
  end

  assign act_x    = act_x_q;
  assign act_y    = act_y_q;
  assign base     = base_q;
  assign mode_on  = (ctrl_q == CTRL_PAL16);
  assign pal_we   = we && (addr[7:6] == RA_PAL_PAGE) && (addr[1:0] != 2'b11);
  assign pal_idx  = addr[2 +: PAL_IDX_W];
  assign pal_lane = addr[1:0];

  // R1: active position moves only on a blanking rising edge
  a_r1_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(vblank && !vb_q) |=> ($stable(act_x_q) && $stable(act_y_q)));
endmodule

// File: rtl/cursor_fetch.sv
module cursor_fetch
  import cursor_pkg::*;
#(
  parameter int POS_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [POS_W-1:0]     px_x,
  input  logic [POS_W-1:0]     px_y,
  input  logic                 px_valid,
  input  logic [POS_W-1:0]     act_x,
  input  logic [POS_W-1:0]     act_y,
  input  logic [BASE_W-1:0]    base,
  input  logic                 mode_on,
  output logic                 mem_rd_en,
  output logic [MADDR_W-1:0]   mem_rd_addr,
  output logic                 s1_valid,
  output logic                 s1_hit,
  output logic [CUR_IDX_W-1:0] s1_col
);
  logic [POS_W:0]       x_end, y_end;
  logic                 cov_x, cov_y, hit;
  logic [POS_W-1:0]     dx, dy;
  logic [CUR_IDX_W-1:0] col, row;
  logic                 valid_q, hit_q;
  logic [CUR_IDX_W-1:0] col_q;

  always_comb begin
    x_end = {1'b0, px_x} + (POS_W+1)'(CUR_DIM);
    y_end = {1'b0, px_y} + (POS_W+1)'(CUR_DIM);
    cov_x = (px_x < act_x) && (x_end >= {1'b0, act_x});
    cov_y = (px_y < act_y) && (y_end >= {1'b0, act_y});
    dx    = px_x - act_x;
    dy    = px_y - act_y;
    col   = dx[CUR_IDX_W-1:0];
    row   = dy[CUR_IDX_W-1:0];
    hit   = px_valid && mode_on && cov_x && cov_y;
  end

  assign mem_rd_en   = hit;
  assign mem_rd_addr = {base, {BASE_LSB{1'b0}}}
                     + (MADDR_W'(row) * MADDR_W'(ROW_BYTES));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      hit_q   <= 1'b0;
      col_q   <= '0;
    end else begin
      valid_q <= px_valid;
      hit_q   <= hit;
      col_q   <= col;
    end
  end

  assign s1_valid = valid_q;
  assign s1_hit   = hit_q;
  assign s1_col   = col_q;

  // R3: a parked X never yields coverage
  a_r3_parked_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (act_x == '0) |=> !s1_hit);
  // R5: a row read is only issued for a valid pixel
  a_r5_read_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> (px_valid && mode_on));
endmodule

// File: rtl/cursor_palette.sv
module cursor_palette
  import cursor_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pal_we,
  input  logic [PAL_IDX_W-1:0] pal_idx,
  input  logic [1:0]           pal_lane,
  input  logic [7:0]           pal_data,
  input  logic                 s1_valid,
  input  logic                 s1_hit,
  input  logic [CUR_IDX_W-1:0] s1_col,
  input  logic [ROW_W-1:0]     row_data,
  output logic                 out_valid,
  output logic                 out_pass,
  output logic [RGB_W-1:0]     out_rgb
);
  logic [PAL_N-1:0][RGB_W-1:0] pal_q;
  logic [PAL_N-1:0][RGB_W-1:0] pal_n;
  logic [PAL_N-1:0]            pal_en;

  for (genvar g = 0; g < PAL_N; g++) begin : g_entry
    always_comb begin
      pal_en[g] = pal_we && (pal_idx == PAL_IDX_W'(g));
      pal_n[g]  = pal_q[g];
      pal_n[g][8*pal_lane +: 8] = pal_data;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         pal_q[g] <= '0;
      else if (pal_en[g]) pal_q[g] <= pal_n[g];
    end
  end

  logic                 transp;
  logic [PAL_IDX_W-1:0] idx;
  logic                 pass_n;
  logic [RGB_W-1:0]     rgb_n;
  logic                 valid_q, pass_q;
  logic [RGB_W-1:0]     rgb_q;

  always_comb begin
    transp = row_data[ROW_W-1-int'(s1_col)];
    idx    = row_data[{s1_col, 2'b00} +: PAL_IDX_W];
    pass_n = !(s1_valid && s1_hit && !transp);
    rgb_n  = pass_n ? '0 : pal_q[idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      pass_q  <= 1'b1;
      rgb_q   <= '0;
    end else begin
      valid_q <= s1_valid;
      pass_q  <= pass_n;
      rgb_q   <= rgb_n;
    end
  end

  assign out_valid = valid_q;
  assign out_pass  = pass_q;
  assign out_rgb   = rgb_q;

  // R9: pass-through pixels carry black
  a_r9_pass_black: assert property (@(posedge clk) disable iff (!rst_n)
    out_pass |-> (out_rgb == '0));
  // R9: stage-two valid follows stage-one valid
  a_r9_stage_valid: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(s1_valid));
endmodule

// File: rtl/cursor_overlay.sv
module cursor_overlay
  import cursor_pkg::*;
#(
  parameter int POS_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_we,
  input  logic [7:0]         reg_addr,
  input  logic [7:0]         reg_wdata,
  input  logic               vblank,
  input  logic [POS_W-1:0]   px_x,
  input  logic [POS_W-1:0]   px_y,
  input  logic               px_valid,
  output logic               mem_rd_en,
  output logic [MADDR_W-1:0] mem_rd_addr,
  input  logic [ROW_W-1:0]   mem_rd_data,
  output logic               out_valid,
  output logic               out_pass,
  output logic [RGB_W-1:0]   out_rgb
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [POS_W-1:0]     act_x, act_y;
  logic [BASE_W-1:0]    base;
  logic                 mode_on;
  logic                 pal_we;
  logic [PAL_IDX_W-1:0] pal_idx;
  logic [1:0]           pal_lane;
  logic                 s1_valid, s1_hit;
  logic [CUR_IDX_W-1:0] s1_col;

  cursor_regs #(.POS_W(POS_W)) u_regs (
    .clk(clk), .rst_n(rst_int_n), .we(reg_we), .addr(reg_addr),
    .wdata(reg_wdata), .vblank(vblank), .act_x(act_x), .act_y(act_y),
    .base(base), .mode_on(mode_on), .pal_we(pal_we), .pal_idx(pal_idx),
    .pal_lane(pal_lane)
  );

  cursor_fetch #(.POS_W(POS_W)) u_fetch (
    .clk(clk), .rst_n(rst_int_n), .px_x(px_x), .px_y(px_y),
    .px_valid(px_valid), .act_x(act_x), .act_y(act_y), .base(base),
    .mode_on(mode_on), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .s1_valid(s1_valid), .s1_hit(s1_hit), .s1_col(s1_col)
  );

  cursor_palette u_pal (
    .clk(clk), .rst_n(rst_int_n), .pal_we(pal_we), .pal_idx(pal_idx),
    .pal_lane(pal_lane), .pal_data(reg_wdata), .s1_valid(s1_valid),
    .s1_hit(s1_hit), .s1_col(s1_col), .row_data(mem_rd_data),
    .out_valid(out_valid), .out_pass(out_pass), .out_rgb(out_rgb)
  );

  // R9: fixed two-cycle latency on the valid flag
  a_r9_latency: assert property (@(posedge clk) disable iff (!rst_int_n)
    out_valid == $past(px_valid, 2));
  // R4: a disabled mode forces pass-through
  a_r4_off_passes: assert property (@(posedge clk) disable iff (!rst_int_n)
    !$past(mode_on, 2) |-> out_pass);
endmodule

// File: tb/tb_cursor_overlay.sv
module tb_cursor_overlay;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         reg_we;
  logic [7:0]   reg_addr, reg_wdata;
  logic         vblank;
  logic [15:0]  px_x, px_y;
  logic         px_valid;
  logic         mem_rd_en;
  logic [23:0]  mem_rd_addr;
  logic [383:0] mem_rd_data;
  logic         out_valid, out_pass;
  logic [23:0]  out_rgb;

  always #2 clk = ~clk;

  cursor_overlay dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .vblank(vblank), .px_x(px_x), .px_y(px_y),
    .px_valid(px_valid), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .mem_rd_data(mem_rd_data), .out_valid(out_valid), .out_pass(out_pass),
    .out_rgb(out_rgb)
  );

  int n_vec = 0;
  int n_bad = 0;

  function automatic logic [7:0] hbyte(input logic [23:0] a);
    logic [31:0] h;
    h = {8'h0, a} * 32'h9E3779B1;
    return h[23:16] ^ h[7:0] ^ h[31:24];
  endfunction

  function automatic logic [383:0] gen_row(input logic [23:0] a);
    logic [383:0] r;
    for (int j = 0; j < 48; j++) r[8*j +: 8] = hbyte(a + 24'(j));
    return r;
  endfunction

  always @(posedge clk) if (mem_rd_en) mem_rd_data <= gen_row(mem_rd_addr);

  // model state
  logic [15:0] m_px, m_py, m_ax, m_ay;
  logic [13:0] m_base;
  logic [7:0]  m_ctrl;
  logic [23:0] m_pal [16];

  function automatic logic [24:0] expect_px(input int sx, input int sy, input logic v);
    int ax, ay, c, r;
    logic [383:0] d;
    logic [3:0] ix;
    ax = int'(m_ax); ay = int'(m_ay);
    if (!v || m_ctrl != 8'h04) return {1'b1, 24'h0};
    if (!(sx < ax && sx + 64 >= ax && sy < ay && sy + 64 >= ay)) return {1'b1, 24'h0};
    c = sx - ax + 64; r = sy - ay + 64;
    d = gen_row({m_base, 10'h0} + 24'(r * 48));
    if (d[383 - c]) return {1'b1, 24'h0};
    ix = d[4*c +: 4];
    return {1'b0, m_pal[ix]};
  endfunction

  logic        e_v [2];
  logic        e_p [2];
  logic [23:0] e_c [2];
  string       e_t [2];
  string       cur_req;

  task automatic chk(input string req, input logic cond, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!cond) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step(input int sx, input int sy, input logic v);
    logic [24:0] e;
    @(negedge clk);
    chk(e_t[1], out_valid == e_v[1], "out_valid", 32'(out_valid), 32'(e_v[1]));
    if (e_v[1]) begin
      chk(e_t[1], out_pass == e_p[1], "out_pass", 32'(out_pass), 32'(e_p[1]));
      chk(e_t[1], out_rgb == e_c[1], "out_rgb", 32'(out_rgb), 32'(e_c[1]));
    end
    e_v[1] = e_v[0]; e_p[1] = e_p[0]; e_c[1] = e_c[0]; e_t[1] = e_t[0];
    e = expect_px(sx, sy, v);
    e_v[0] = v; e_p[0] = e[24]; e_c[0] = e[23:0]; e_t[0] = cur_req;
    px_x = 16'(sx); px_y = 16'(sy); px_valid = v;
  endtask

  task automatic flush();
    step(0, 0, 1'b0);
    step(0, 0, 1'b0);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    case (a)
      8'h00: m_px[7:0]  = d;
      8'h01: m_px[15:8] = d;
      8'h02: m_py[7:0]  = d;
      8'h03: m_py[15:8] = d;
      8'h04: m_base[7:0]  = d;
      8'h05: m_base[13:8] = d[5:0];
      8'h06: m_ctrl = d;
      default: if (a[7:6] == 2'b01 && a[1:0] != 2'b11) m_pal[a[5:2]][8*a[1:0] +: 8] = d;
    endcase
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic set_pos(input int x, input int y);
    wr(8'h00, 8'(x)); wr(8'h01, 8'(x >> 8));
    wr(8'h02, 8'(y)); wr(8'h03, 8'(y >> 8));
  endtask

  task automatic vb_pulse();
    @(negedge clk); vblank = 1'b1;
    m_ax = m_px; m_ay = m_py;
    @(negedge clk); vblank = 1'b0;
  endtask

  task automatic scan(input int x0, input int x1, input int y0, input int y1);
    for (int y = y0; y <= y1; y++)
      for (int x = x0; x <= x1; x++) step(x, y, 1'b1);
    flush();
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog timeout actual=running expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    vblank = 1'b0; px_x = '0; px_y = '0; px_valid = 1'b0;
    m_px = '0; m_py = '0; m_ax = '0; m_ay = '0; m_base = '0; m_ctrl = '0;
    for (int i = 0; i < 16; i++) m_pal[i] = '0;
    for (int i = 0; i < 2; i++) begin e_v[i] = 0; e_p[i] = 1; e_c[i] = 0; e_t[i] = "R10"; end
    cur_req = "R10";
    repeat (3) @(negedge clk);
    // R10: reset state at the outputs
    chk("R10", out_valid == 1'b0, "reset out_valid", 32'(out_valid), 0);
    chk("R10", out_pass == 1'b1, "reset out_pass", 32'(out_pass), 1);
    chk("R10", out_rgb == 24'h0, "reset out_rgb", 32'(out_rgb), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R10: control starts at 0, so a covered area still passes
    set_pos(100, 50); vb_pulse();
    scan(36, 99, 0, 0);
    cur_req = "R10"; scan(40, 44, 10, 10);

    // R8 palette load, R5 base, R4 enable
    for (int i = 0; i < 16; i++)
      for (int k = 0; k < 3; k++) wr(8'(8'h40 + 4*i + k), 8'($urandom));
    wr(8'h04, 8'h3A); wr(8'h05, 8'h05);
    wr(8'h06, 8'h04);
    cur_req = "R2"; scan(30, 110, 0, 0);
    cur_req = "R6"; scan(36, 99, 20, 21);
    cur_req = "R7"; scan(36, 99, 49, 49);
    cur_req = "R2"; scan(60, 70, 48, 52);

    // R8: lane 3 writes change nothing
    for (int i = 0; i < 16; i++) wr(8'(8'h43 + 4*i), 8'hFF);
    cur_req = "R8"; scan(36, 99, 30, 33);

    // R5: base high bits 7:6 ignored
    wr(8'h05, 8'hC7); wr(8'h04, 8'h91);
    cur_req = "R5"; scan(36, 99, 40, 41);

    // R1: pending position not yet active
    set_pos(200, 120);
    cur_req = "R1"; scan(36, 99, 12, 12);
    cur_req = "R1"; scan(136, 199, 60, 60);
    vb_pulse();
    cur_req = "R1"; scan(136, 199, 60, 61);
    cur_req = "R1"; scan(36, 99, 12, 12);

    // R2: cursor hanging off the top-left corner
    set_pos(10, 5); vb_pulse();
    cur_req = "R2"; scan(0, 15, 0, 6);

    // R3: parking at X = 0 hides it
    wr(8'h00, 8'h00); wr(8'h01, 8'h00); vb_pulse();
    cur_req = "R3"; scan(0, 70, 0, 4);

    // R4: other control values disable
    set_pos(100, 50); vb_pulse();
    wr(8'h06, 8'h00);
    cur_req = "R4"; scan(36, 99, 0, 1);
    wr(8'h06, 8'h05);
    cur_req = "R4"; scan(36, 99, 2, 3);
    wr(8'h06, 8'h04);
    cur_req = "R4"; scan(36, 99, 4, 4);

    // R9: random stream with gaps
    cur_req = "R9";
    for (int blk = 0; blk < 12; blk++) begin
      set_pos(int'($urandom_range(0, 300)), int'($urandom_range(0, 200)));
      vb_pulse();
      for (int n = 0; n < 400; n++)
        step(int'($urandom_range(0, 320)), int'($urandom_range(0, 220)),
             1'($urandom_range(0, 3) != 0));
      flush();
    end

    finish_run();
  end
endmodule